// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the control state machine of a dispenser that offers two drinks, regular and diet, at one price of 45 cents. Upstream logic debounces the coin and button inputs and turns each into a single-cycle strobe. The controller counts the coins it receives in 5-cent steps. It keeps the running credit only as a state, with no adder and no subtractor in the datapath.

The credit is a one-hot ladder with one rung for each 5-cent step below the price. A nickel moves the credit up one rung, a dime two rungs and a quarter five rungs. Any move that would reach or pass the top rung enters a single paid state. No change is ever returned. While the block is paid it ignores coins. A selection then produces a one-cycle dispense pulse, and the machine returns to zero credit. The `accepting` output tells the front panel when coins are taken.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `accepting` is 1, both dispense outputs are 0, and the credit is zero, so nine nickels are needed to pay.
- R2: In the accepting state, a nickel strobe adds one 5-cent step, a dime adds two and a quarter adds five. The credit becomes visible at the clock edge that samples the strobe.
- R3: When the credit reaches exactly 45 cents, `accepting` goes to 0 at the sampling edge.
- R4: A coin that takes the credit past 45 cents (for example to 50 or 65) gives the same paid state as exactly 45. No credit is carried past a purchase, so the next sale again needs a full 45 cents.
- R5: If several coin strobes are high in one cycle, only one is counted, with the priority quarter, then dime, then nickel.
- R6: In the paid state, coin strobes are ignored. `accepting` stays 0 and no dispense output is raised.
- R7: A `soda` strobe in the paid state raises `give_soda` for exactly one full clock cycle, starting at the next edge. In the cycle after that pulse, `accepting` is 1 again and the credit is zero.
- R8: A `diet` strobe in the paid state raises `give_diet` for exactly one full clock cycle. The machine then returns to zero credit in the same way.
- R9: If `soda` and `diet` are both high in the paid state, only `give_soda` pulses.
- R10: While `accepting` is 1, selection strobes are ignored. No dispense output rises and the credit held so far is unchanged.
- R11: At most one of `accepting`, `give_soda` and `give_diet` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| nickel | input | 1 | 5-cent coin strobe, one cycle per coin |
| dime | input | 1 | 10-cent coin strobe, one cycle per coin |
| quarter | input | 1 | 25-cent coin strobe, one cycle per coin |
| soda | input | 1 | Regular drink selection strobe |
| diet | input | 1 | Diet drink selection strobe |
| give_soda | output | 1 | Regular drink release pulse (registered state output) |
| give_diet | output | 1 | Diet drink release pulse (registered state output) |
| accepting | output | 1 | High while coins are being taken |

## Verification
All outputs come straight from registered state. The effect of any strobe sampled at a rising edge is therefore due one edge later, and a dispense pulse is followed by the return to accepting on the edge after it. The bench drives and clears every strobe on falling edges and reads the outputs at the next falling edge, which is half a period after the edge that updates them. The hidden credit is read back through the ports: the bench counts how many single nickels drive `accepting` low and compares that count with nine minus the number of steps it expects to be held.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    PH_CREDIT = 2'd0,
    PH_PAID   = 2'd1,
    PH_SODA   = 2'd2,
    PH_DIET   = 2'd3
  } vend_phase_e;

  typedef enum logic [1:0] {
    COIN_NONE    = 2'd0,
    COIN_NICKEL  = 2'd1,
    COIN_DIME    = 2'd2,
    COIN_QUARTER = 2'd3
  } vend_coin_e;

endpackage

// File: rtl/vend_coin_arbiter.sv
module vend_coin_arbiter
  import vend_pkg::*;
(
  input  logic       nickel,
  input  logic       dime,
  input  logic       quarter,
  output vend_coin_e coin_sel
);

  always_comb begin
    if (quarter)     coin_sel = COIN_QUARTER;
    else if (dime)   coin_sel = COIN_DIME;
    else if (nickel) coin_sel = COIN_NICKEL;
    else             coin_sel = COIN_NONE;
  end

  // R5: the quarter always wins when it is present
  always_comb begin
    if (quarter) a_r5_quarter_wins: assert (coin_sel == COIN_QUARTER);
  end

endmodule

// File: rtl/vend_credit_ladder.sv
module vend_credit_ladder
  import vend_pkg::*;
#(
  parameter int unsigned PRICE_STEPS   = 9,
  parameter int unsigned DIME_STEPS    = 2,
  parameter int unsigned QUARTER_STEPS = 5
) (
  input  logic [PRICE_STEPS-1:0] credit_q,
  input  vend_coin_e             coin_sel,
  output logic [PRICE_STEPS-1:0] credit_d,
  output logic                   reach_paid
);

  logic [PRICE_STEPS-1:0] ovf_nickel;
  logic [PRICE_STEPS-1:0] ovf_dime;
  logic [PRICE_STEPS-1:0] ovf_quarter;

  logic sel_none, sel_nickel, sel_dime, sel_quarter;
  assign sel_none    = (coin_sel == COIN_NONE);
  assign sel_nickel  = (coin_sel == COIN_NICKEL);
  assign sel_dime    = (coin_sel == COIN_DIME);
  assign sel_quarter = (coin_sel == COIN_QUARTER);

  for (genvar i = 0; i < PRICE_STEPS; i++) begin : g_rung
    logic from_nickel, from_dime, from_quarter;

    if (i >= 1) begin : g_n
      assign from_nickel = credit_q[i-1];
    end else begin : g_n0
      assign from_nickel = 1'b0;
    end

    if (i >= DIME_STEPS) begin : g_d
      assign from_dime = credit_q[i-DIME_STEPS];
    end else begin : g_d0
      assign from_dime = 1'b0;
    end

    if (i >= QUARTER_STEPS) begin : g_q
      assign from_quarter = credit_q[i-QUARTER_STEPS];
    end else begin : g_q0
      assign from_quarter = 1'b0;
    end

    assign credit_d[i] = (sel_none    & credit_q[i])
                       | (sel_nickel  & from_nickel)
                       | (sel_dime    & from_dime)
                       | (sel_quarter & from_quarter);

    if (i + 1 >= PRICE_STEPS) begin : g_on
      assign ovf_nickel[i] = credit_q[i];
    end else begin : g_on0
      assign ovf_nickel[i] = 1'b0;
    end

    if (i + DIME_STEPS >= PRICE_STEPS) begin : g_od
      assign ovf_dime[i] = credit_q[i];
    end else begin : g_od0
      assign ovf_dime[i] = 1'b0;
    end

    if (i + QUARTER_STEPS >= PRICE_STEPS) begin : g_oq
      assign ovf_quarter[i] = credit_q[i];
    end else begin : g_oq0
      assign ovf_quarter[i] = 1'b0;
    end
  end

  assign reach_paid = (sel_nickel  & (|ovf_nickel))
                    | (sel_dime    & (|ovf_dime))
                    | (sel_quarter & (|ovf_quarter));

  // R2: a coin that does not pay keeps the credit on exactly one rung
  always_comb begin
    if ($countones(credit_q) == 1 && !reach_paid)
      a_r2_rung_kept: assert ($countones(credit_d) == 1);
  end

endmodule

// File: rtl/vend_phase_ctrl.sv
module vend_phase_ctrl
  import vend_pkg::*;
(
  input  vend_phase_e phase_q,
  input  logic        reach_paid,
  input  logic        soda,
  input  logic        diet,
  output vend_phase_e phase_d
);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_CREDIT: if (reach_paid) phase_d = PH_PAID;
      PH_PAID: begin
        if (soda)      phase_d = PH_SODA;
        else if (diet) phase_d = PH_DIET;
      end
      PH_SODA:  phase_d = PH_CREDIT;
      PH_DIET:  phase_d = PH_CREDIT;
      default:  phase_d = PH_CREDIT;
    endcase
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned PRICE_STEPS   = 9,
  parameter int unsigned DIME_STEPS    = 2,
  parameter int unsigned QUARTER_STEPS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nickel,
  input  logic dime,
  input  logic quarter,
  input  logic soda,
  input  logic diet,
  output logic give_soda,
  output logic give_diet,
  output logic accepting
);

  localparam logic [PRICE_STEPS-1:0] ZERO_CREDIT = {{(PRICE_STEPS-1){1'b0}}, 1'b1};

  vend_phase_e            phase_q, phase_d;
  logic [PRICE_STEPS-1:0] credit_q, credit_d, ladder_d;
  vend_coin_e             coin_sel;
  logic                   reach_paid;
  logic                   credit_en;
  logic                   in_credit;

  assign in_credit = (phase_q == PH_CREDIT);

  vend_coin_arbiter u_arb (
    .nickel   (nickel),
    .dime     (dime),
    .quarter  (quarter),
    .coin_sel (coin_sel)
  );

  vend_credit_ladder #(
    .PRICE_STEPS   (PRICE_STEPS),
    .DIME_STEPS    (DIME_STEPS),
    .QUARTER_STEPS (QUARTER_STEPS)
  ) u_ladder (
    .credit_q   (credit_q),
    .coin_sel   (coin_sel),
    .credit_d   (ladder_d),
    .reach_paid (reach_paid)
  );

  vend_phase_ctrl u_phase (
    .phase_q    (phase_q),
    .reach_paid (reach_paid && in_credit),
    .soda       (soda),
    .diet       (diet),
    .phase_d    (phase_d)
  );

  // Credit moves only on an accepted coin; paying clears it to zero
  assign credit_en = in_credit && (coin_sel != COIN_NONE);

  always_comb begin
    if (reach_paid) credit_d = ZERO_CREDIT;
    else            credit_d = ladder_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CREDIT;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= ZERO_CREDIT;
    end else if (credit_en) begin
      credit_q <= credit_d;
    end
  end

  assign accepting = in_credit;
  assign give_soda = (phase_q == PH_SODA);
  assign give_diet = (phase_q == PH_DIET);

  // R11: one output active at a time
  a_r11_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accepting, give_soda, give_diet}));

  // R2: exactly one credit rung is held
  a_r2_credit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(credit_q) == 1);

  // R2: a lone nickel at zero credit lands on the second rung
  a_r2_nickel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_credit && credit_q == ZERO_CREDIT && nickel && !dime && !quarter)
    |=> (credit_q == (ZERO_CREDIT << 1)));

  // R6: coins cannot leave the paid state
  a_r6_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAID && !soda && !diet) |=> (phase_q == PH_PAID));

  // R7 and R9: a soda press while paid dispenses a regular drink
  a_r7_soda_dispense: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAID && soda) |=> give_soda);

  // R8: a lone diet press while paid dispenses a diet drink
  a_r8_diet_dispense: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAID && diet && !soda) |=> give_diet);

  // R7: the pulse lasts one cycle and is followed by zero credit
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (give_soda || give_diet) |=> (accepting && credit_q == ZERO_CREDIT));

  // R10: selections are ignored while accepting
  a_r10_select_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_credit && !reach_paid) |=> accepting);

endmodule

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;

  logic clk = 1'b0;
  logic rst_n;
  logic nickel, dime, quarter, soda, diet;
  logic give_soda, give_diet, accepting;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  vend_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .nickel    (nickel),
    .dime      (dime),
    .quarter   (quarter),
    .soda      (soda),
    .diet      (diet),
    .give_soda (give_soda),
    .give_diet (give_diet),
    .accepting (accepting)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Drive one cycle of strobes at a falling edge; outputs are read at the next falling edge
  task automatic pulse(input logic n, input logic d, input logic q, input logic s, input logic t);
    nickel = n; dime = d; quarter = q; soda = s; diet = t;
    @(negedge clk);
    nickel = 0; dime = 0; quarter = 0; soda = 0; diet = 0;
  endtask

  task automatic idle();
    pulse(0, 0, 0, 0, 0);
  endtask

  // Count the nickels needed to reach the paid state
  task automatic nickels_to_pay(output int n);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      pulse(1, 0, 0, 0, 0);
      n++;
      if (!accepting) break;
    end
  endtask

  task automatic finish_sale();
    pulse(0, 0, 0, 1, 0);
    idle();
  endtask

  task automatic t_reset();
    int n;
    rst_n = 0;
    nickel = 0; dime = 0; quarter = 0; soda = 0; diet = 0;
    @(negedge clk);
    check(accepting == 1 && give_soda == 0 && give_diet == 0, "R1 reset outputs",
          {accepting, give_soda, give_diet}, 3'b100);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(accepting == 1, "R1 accepting after reset", accepting, 1);
    nickels_to_pay(n);
    check(n == 9, "R1 zero credit after reset", n, 9);
    check(accepting == 0, "R3 exact 45 pays", accepting, 0);
    finish_sale();
  endtask

  task automatic t_coin_values();
    int n;
    pulse(0, 1, 0, 0, 0);
    nickels_to_pay(n);
    check(n == 7, "R2 dime is two steps", n, 7);
    finish_sale();
    pulse(0, 0, 1, 0, 0);
    nickels_to_pay(n);
    check(n == 4, "R2 quarter is five steps", n, 4);
    finish_sale();
  endtask

  task automatic t_exact_and_over();
    pulse(0, 1, 0, 0, 0);
    pulse(0, 1, 0, 0, 0);
    pulse(0, 0, 1, 0, 0);
    check(accepting == 0, "R3 dime dime quarter pays", accepting, 0);
    finish_sale();
    for (int k = 0; k < 4; k++) pulse(0, 1, 0, 0, 0);
    check(accepting == 1, "R2 forty cents still accepting", accepting, 1);
    pulse(0, 0, 1, 0, 0);
    check(accepting == 0, "R4 sixty-five cents pays", accepting, 0);
    finish_sale();
    pulse(0, 0, 1, 0, 0);
    pulse(0, 0, 1, 0, 0);
    check(accepting == 0, "R4 fifty cents pays", accepting, 0);
    finish_sale();
  endtask

  task automatic t_no_carry();
    int n;
    for (int k = 0; k < 3; k++) pulse(0, 0, 1, 0, 0);
    finish_sale();
    nickels_to_pay(n);
    check(n == 9, "R4 no credit carried", n, 9);
    finish_sale();
  endtask

  task automatic t_priority();
    int n;
    pulse(1, 1, 1, 0, 0);
    nickels_to_pay(n);
    check(n == 4, "R5 quarter wins", n, 4);
    finish_sale();
    pulse(1, 1, 0, 0, 0);
    nickels_to_pay(n);
    check(n == 7, "R5 dime beats nickel", n, 7);
    finish_sale();
  endtask

  task automatic t_lockout();
    int n;
    pulse(0, 0, 1, 0, 0);
    pulse(0, 0, 1, 0, 0);
    pulse(1, 1, 1, 0, 0);
    check(accepting == 0 && give_soda == 0 && give_diet == 0, "R6 coins ignored when paid",
          {accepting, give_soda, give_diet}, 0);
    idle();
    check(accepting == 0, "R6 still paid", accepting, 0);
    finish_sale();
    nickels_to_pay(n);
    check(n == 9, "R6 locked coins not credited", n, 9);
    finish_sale();
  endtask

  task automatic t_dispense();
    pulse(0, 0, 1, 0, 0);
    pulse(0, 0, 1, 0, 0);
    pulse(0, 0, 0, 1, 0);
    check(give_soda == 1 && give_diet == 0 && accepting == 0, "R7 soda pulse",
          {give_soda, give_diet, accepting}, 3'b100);
    idle();
    check(give_soda == 0 && accepting == 1, "R7 soda one cycle", {give_soda, accepting}, 2'b01);
    pulse(0, 0, 1, 0, 0);
    pulse(0, 0, 1, 0, 0);
    pulse(0, 0, 0, 0, 1);
    check(give_diet == 1 && give_soda == 0 && accepting == 0, "R8 diet pulse",
          {give_soda, give_diet, accepting}, 3'b010);
    idle();
    check(give_diet == 0 && accepting == 1, "R8 diet one cycle", {give_diet, accepting}, 2'b01);
    pulse(0, 0, 1, 0, 0);
    pulse(0, 0, 1, 0, 0);
    pulse(0, 0, 0, 1, 1);
    check(give_soda == 1 && give_diet == 0, "R9 soda wins tie", {give_soda, give_diet}, 2'b10);
    idle();
    check(give_soda == 0 && give_diet == 0 && accepting == 1, "R9 single pulse",
          {give_soda, give_diet, accepting}, 3'b001);
  endtask

  task automatic t_select_ignored();
    int n;
    pulse(0, 1, 0, 0, 0);
    pulse(0, 0, 0, 1, 1);
    check(give_soda == 0 && give_diet == 0 && accepting == 1, "R10 select ignored",
          {give_soda, give_diet, accepting}, 3'b001);
    idle();
    check(give_soda == 0 && give_diet == 0, "R11 no late pulse", {give_soda, give_diet}, 0);
    nickels_to_pay(n);
    check(n == 7, "R10 credit kept", n, 7);
    finish_sale();
  endtask

  initial begin
    t_reset();
    t_coin_values();
    t_exact_and_over();
    t_no_carry();
    t_priority();
    t_lockout();
    t_dispense();
    t_select_ignored();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule